// File: doc/BRIEF.md
# CAN Message Buffer Filter and Transmit Arbiter

This block does the message-buffer bookkeeping for a CAN controller. It sits beside the bit-level protocol engine and does not itself handle bit timing, stuffing, CRC or error counting. It holds fifteen buffer slots. Each slot has an identifier, a standard/extended flag, a direction, a transmit priority and a ready flag. For receive slots the ready flag means "empty, may accept". For transmit slots it means "pending transmission".

When the protocol engine reports a received frame, the block picks the receive slot that takes it. The choice uses acceptance masks: slots 0 to 13 share one mask, and the last slot has a private mask so that it can act as a catch-all path. A remote request frame is matched against the transmit slots instead, and it re-arms the slot it hits. On the transmit side, a priority arbiter offers the ready transmit slot with the highest programmed priority to the protocol engine. It holds that offer until the engine reports completion or lost arbitration.

A free-running 16-bit timestamp counter advances on a bit-time tick. Its value is stored into a slot whenever that slot completes a reception or a transmission.

Top module: `can_mb_ctrl`

## Requirements
- R1: After reset, rx_hit_o, tx_valid_o, ts_o and every bit of rdy_o are 0. Both masks are all ones, and every slot is an empty-flag-clear receive slot.
- R2: A data frame matches slot i (i < 14) when the slot is receive and ready, its extended flag equals rx_ext_i, and the identifiers agree on every bit where the shared mask is 1. Bits where the mask is 0 are ignored. Standard identifiers sit in bits [10:0], and for them only mask bits [10:0] are used.
- R3: When several slots match, the lowest-indexed one takes the frame, and its rdy_o bit clears (slot full). A full slot no longer matches.
- R4: Slot 14 is compared using its own mask, and only when none of slots 0 to 13 matches. When nothing matches, rx_hit_o stays 0 and no rdy_o bit changes.
- R5: Extended frames compare all 29 identifier bits. A standard frame never matches an extended slot, even when the low 11 bits agree.
- R6: A remote request frame (rx_rtr_i=1) is compared against transmit slots only, with the same mask rules. The lowest matching transmit slot gets its rdy_o bit set, and rx_hit_o/rx_rmt_o report it.
- R7: Among ready transmit slots, the one with the numerically highest priority is offered on tx_idx_o. On equal priority, the lower index wins.
- R8: Once tx_valid_o is high, tx_idx_o and tx_valid_o hold until tx_done_i or tx_lost_i, even if a better slot becomes ready. tx_done_i clears that slot's rdy_o bit. Either pulse drops tx_valid_o for one cycle, and arbitration then restarts.
- R9: ts_o increments by one on each clock with tick_i high, holds otherwise, and wraps from 0xFFFF to 0.
- R10: On an accepted data frame, and on tx_done_i, the current ts_o value (before that edge's increment) is stored for the slot. It is readable on ts_rd_o via ts_rd_idx_i.
- R11: rx_hit_o, rx_idx_o and rx_rmt_o are registered. They are valid for exactly the one cycle after the cycle in which rx_valid_i was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Slot configuration write strobe |
| cfg_idx_i | input | 4 | Slot written |
| cfg_id_i | input | 29 | Slot identifier |
| cfg_ext_i | input | 1 | Slot holds an extended identifier |
| cfg_tx_i | input | 1 | 1 = transmit slot, 0 = receive slot |
| cfg_prio_i | input | 4 | Transmit priority, larger wins |
| cfg_rdy_i | input | 1 | Ready flag (rx: empty, tx: pending) |
| mask_we_i | input | 1 | Mask write strobe |
| mask_sel_i | input | 1 | 0 = shared mask, 1 = slot-14 mask |
| mask_i | input | 29 | Mask value, 1 = compare |
| rx_valid_i | input | 1 | Received frame strobe |
| rx_id_i | input | 29 | Received identifier |
| rx_ext_i | input | 1 | Received frame is extended |
| rx_rtr_i | input | 1 | Received frame is a remote request |
| rx_hit_o | output | 1 | Frame was placed in a slot |
| rx_idx_o | output | 4 | Slot that took the frame |
| rx_rmt_o | output | 1 | Result refers to a remote request |
| tx_valid_o | output | 1 | A transmit slot is offered |
| tx_idx_o | output | 4 | Offered transmit slot |
| tx_done_i | input | 1 | Protocol engine finished the offered slot |
| tx_lost_i | input | 1 | Protocol engine lost arbitration |
| tick_i | input | 1 | Bit-time tick for the timestamp |
| ts_o | output | 16 | Current timestamp |
| ts_rd_idx_i | input | 4 | Slot whose stored timestamp is read |
| ts_rd_o | output | 16 | Stored timestamp of that slot |
| rdy_o | output | 15 | Ready flag of every slot |

## Verification
The assertions assume that the protocol engine pulses tx_done_i or tx_lost_i only while tx_valid_o is high, and never both in the same cycle. The bench drives those pulses only after it has seen an offer, one at a time. The assertions also take rx_valid_i as a single-cycle strobe. The bench raises it for one clock per frame and leaves tick_i low whenever it compares a captured timestamp. Sequences are ordered so that the first transmit slot made ready is the one checked. A tie between equal priorities is created while another slot is held, so both slots are ready at the same arbitration.

// File: rtl/can_mb_pkg.sv
package can_mb_pkg;
  parameter int ID_W   = 29;
  parameter int STD_W  = 11;
  parameter int PRIO_W = 4;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ext;
    logic              is_tx;
    logic [PRIO_W-1:0] prio;
    logic              rdy;
  } slot_t;
endpackage

// File: rtl/can_mb_filter.sv
module can_mb_filter import can_mb_pkg::*; #(
  parameter int NUM_BUF = 15,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic [NUM_BUF-1:0] rx_free_i,
  input  logic [NUM_BUF-1:0] tx_slot_i,
  input  logic [NUM_BUF-1:0] ext_i,
  input  logic [ID_W-1:0]    id_i [NUM_BUF],
  input  logic [ID_W-1:0]    mask_shared_i,
  input  logic [ID_W-1:0]    mask_catch_i,
  input  logic [ID_W-1:0]    rx_id_i,
  input  logic               rx_ext_i,
  input  logic               rx_rtr_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  localparam logic [ID_W-1:0] STD_KEEP = ID_W'((64'd1 << STD_W) - 1);

  logic [NUM_BUF-1:0] match;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_cmp
    logic [ID_W-1:0] mask_raw, mask_eff;
    logic            cand;
    assign mask_raw = (g == NUM_BUF-1) ? mask_catch_i : mask_shared_i;
    assign mask_eff = rx_ext_i ? mask_raw : (mask_raw & STD_KEEP);
    assign cand     = rx_rtr_i ? tx_slot_i[g] : rx_free_i[g];
    assign match[g] = cand && (ext_i[g] == rx_ext_i) &&
                      (((id_i[g] ^ rx_id_i) & mask_eff) == '0);
  end

  // catch slot only when no regular slot matches
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_BUF-2; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
    if (!hit_o && match[NUM_BUF-1]) begin
      hit_o = 1'b1;
      idx_o = IDX_W'(NUM_BUF-1);
    end
  end
endmodule

// File: rtl/can_mb_tx_arb.sv
module can_mb_tx_arb import can_mb_pkg::*; #(
  parameter int NUM_BUF = 15,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic [NUM_BUF-1:0] req_i,
  input  logic [PRIO_W-1:0]  prio_i [NUM_BUF],
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lower index on ties
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (req_i[i] && (!hit_o || prio_i[i] > best)) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/can_mb_ts.sv
module can_mb_ts #(
  parameter int TS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  output logic [TS_W-1:0] ts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ts_o <= '0;
    else if (tick_i) ts_o <= ts_o + 1'b1;
  end
endmodule

// File: rtl/can_mb_ctrl.sv
module can_mb_ctrl import can_mb_pkg::*; #(
  parameter int NUM_BUF = 15,
  parameter int TS_W    = 16,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [ID_W-1:0]    cfg_id_i,
  input  logic               cfg_ext_i,
  input  logic               cfg_tx_i,
  input  logic [PRIO_W-1:0]  cfg_prio_i,
  input  logic               cfg_rdy_i,
  input  logic               mask_we_i,
  input  logic               mask_sel_i,
  input  logic [ID_W-1:0]    mask_i,
  input  logic               rx_valid_i,
  input  logic [ID_W-1:0]    rx_id_i,
  input  logic               rx_ext_i,
  input  logic               rx_rtr_i,
  output logic               rx_hit_o,
  output logic [IDX_W-1:0]   rx_idx_o,
  output logic               rx_rmt_o,
  output logic               tx_valid_o,
  output logic [IDX_W-1:0]   tx_idx_o,
  input  logic               tx_done_i,
  input  logic               tx_lost_i,
  input  logic               tick_i,
  output logic [TS_W-1:0]    ts_o,
  input  logic [IDX_W-1:0]   ts_rd_idx_i,
  output logic [TS_W-1:0]    ts_rd_o,
  output logic [NUM_BUF-1:0] rdy_o
);
  slot_t              slots   [NUM_BUF];
  logic [TS_W-1:0]    ts_mem  [NUM_BUF];
  logic [ID_W-1:0]    slot_id [NUM_BUF];
  logic [PRIO_W-1:0]  slot_pr [NUM_BUF];
  logic [NUM_BUF-1:0] rx_free, tx_slot, slot_ext, tx_req;
  logic [ID_W-1:0]    mask_shared, mask_catch;
  logic               f_hit, a_hit;
  logic [IDX_W-1:0]   f_idx, a_idx;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_view
    assign slot_id[g]  = slots[g].id;
    assign slot_pr[g]  = slots[g].prio;
    assign slot_ext[g] = slots[g].ext;
    assign tx_slot[g]  = slots[g].is_tx;
    assign rx_free[g]  = !slots[g].is_tx && slots[g].rdy;
    assign tx_req[g]   = slots[g].is_tx && slots[g].rdy;
    assign rdy_o[g]    = slots[g].rdy;
  end

  can_mb_filter #(.NUM_BUF(NUM_BUF)) u_filter (
    .rx_free_i     (rx_free),
    .tx_slot_i     (tx_slot),
    .ext_i         (slot_ext),
    .id_i          (slot_id),
    .mask_shared_i (mask_shared),
    .mask_catch_i  (mask_catch),
    .rx_id_i       (rx_id_i),
    .rx_ext_i      (rx_ext_i),
    .rx_rtr_i      (rx_rtr_i),
    .hit_o         (f_hit),
    .idx_o         (f_idx)
  );

  can_mb_tx_arb #(.NUM_BUF(NUM_BUF)) u_arb (
    .req_i  (tx_req),
    .prio_i (slot_pr),
    .hit_o  (a_hit),
    .idx_o  (a_idx)
  );

  can_mb_ts #(.TS_W(TS_W)) u_ts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .ts_o   (ts_o)
  );

  assign ts_rd_o = (int'(ts_rd_idx_i) < NUM_BUF) ? ts_mem[ts_rd_idx_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        slots[i]  <= '0;
        ts_mem[i] <= '0;
      end
      mask_shared <= '1;
      mask_catch  <= '1;
      rx_hit_o    <= 1'b0;
      rx_idx_o    <= '0;
      rx_rmt_o    <= 1'b0;
      tx_valid_o  <= 1'b0;
      tx_idx_o    <= '0;
    end else begin
      rx_hit_o <= 1'b0;
      if (rx_valid_i) begin
        rx_hit_o <= f_hit;
        rx_idx_o <= f_idx;
        rx_rmt_o <= rx_rtr_i;
        if (f_hit) begin
          if (rx_rtr_i) begin
            slots[f_idx].rdy <= 1'b1;
          end else begin
            slots[f_idx].rdy <= 1'b0;
            ts_mem[f_idx]    <= ts_o;
          end
        end
      end

      if (tx_valid_o) begin
        if (tx_done_i) begin
          tx_valid_o          <= 1'b0;
          slots[tx_idx_o].rdy <= 1'b0;
          ts_mem[tx_idx_o]    <= ts_o;
        end else if (tx_lost_i) begin
          tx_valid_o <= 1'b0;
        end
      end else if (a_hit) begin
        tx_valid_o <= 1'b1;
        tx_idx_o   <= a_idx;
      end

      if (cfg_we_i && int'(cfg_idx_i) < NUM_BUF) begin
        slots[cfg_idx_i] <= '{id: cfg_id_i, ext: cfg_ext_i, is_tx: cfg_tx_i,
                               prio: cfg_prio_i, rdy: cfg_rdy_i};
      end

      if (mask_we_i) begin
        if (mask_sel_i) mask_catch  <= mask_i;
        else            mask_shared <= mask_i;
      end
    end
  end
endmodule

// File: rtl/can_mb_chk.sv
module can_mb_chk #(
  parameter int NUM_BUF = 15,
  parameter int TS_W    = 16,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_valid_i,
  input logic             rx_hit_o,
  input logic [IDX_W-1:0] rx_idx_o,
  input logic             tx_valid_o,
  input logic [IDX_W-1:0] tx_idx_o,
  input logic             tx_done_i,
  input logic             tx_lost_i,
  input logic             tick_i,
  input logic [TS_W-1:0]  ts_o
);
  // R8
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_done_i && !tx_lost_i |=> tx_valid_o && $stable(tx_idx_o));

  // R8
  tx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && (tx_done_i || tx_lost_i) |=> !tx_valid_o);

  // R7
  tx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> int'(tx_idx_o) < NUM_BUF);

  // R9
  ts_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> ts_o == TS_W'($past(ts_o) + 1'b1));

  // R9
  ts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(ts_o));

  // R11
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_hit_o |-> $past(rx_valid_i) && int'(rx_idx_o) < NUM_BUF);

  // R11
  rx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !rx_hit_o);
endmodule

bind can_mb_ctrl can_mb_chk #(.NUM_BUF(NUM_BUF), .TS_W(TS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .rx_hit_o   (rx_hit_o),
  .rx_idx_o   (rx_idx_o),
  .tx_valid_o (tx_valid_o),
  .tx_idx_o   (tx_idx_o),
  .tx_done_i  (tx_done_i),
  .tx_lost_i  (tx_lost_i),
  .tick_i     (tick_i),
  .ts_o       (ts_o)
);

// File: tb/can_mb_ctrl_test.sv
module can_mb_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 0, cfg_ext = 0, cfg_tx = 0, cfg_rdy = 0;
  logic [3:0]  cfg_idx = 0, cfg_prio = 0;
  logic [28:0] cfg_id = 0, mask = 0, rx_id = 0;
  logic        mask_we = 0, mask_sel = 0;
  logic        rx_valid = 0, rx_ext = 0, rx_rtr = 0;
  logic        rx_hit, rx_rmt, tx_valid;
  logic [3:0]  rx_idx, tx_idx, ts_rd_idx = 0;
  logic        tx_done = 0, tx_lost = 0, tick = 0;
  logic [15:0] ts, ts_rd;
  logic [14:0] rdy;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mb_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_id_i(cfg_id), .cfg_ext_i(cfg_ext),
    .cfg_tx_i(cfg_tx), .cfg_prio_i(cfg_prio), .cfg_rdy_i(cfg_rdy),
    .mask_we_i(mask_we), .mask_sel_i(mask_sel), .mask_i(mask),
    .rx_valid_i(rx_valid), .rx_id_i(rx_id), .rx_ext_i(rx_ext), .rx_rtr_i(rx_rtr),
    .rx_hit_o(rx_hit), .rx_idx_o(rx_idx), .rx_rmt_o(rx_rmt),
    .tx_valid_o(tx_valid), .tx_idx_o(tx_idx), .tx_done_i(tx_done), .tx_lost_i(tx_lost),
    .tick_i(tick), .ts_o(ts), .ts_rd_idx_i(ts_rd_idx), .ts_rd_o(ts_rd), .rdy_o(rdy)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_slot(int idx, logic [28:0] id, bit ext, bit tx, int prio, bit r);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_id = id; cfg_ext = ext;
    cfg_tx = tx; cfg_prio = 4'(prio); cfg_rdy = r;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_mask(bit sel, logic [28:0] m);
    @(negedge clk);
    mask_we = 1; mask_sel = sel; mask = m;
    @(negedge clk);
    mask_we = 0;
  endtask

  // returns at the negedge where the registered result is visible
  task automatic send_rx(logic [28:0] id, bit ext, bit rtr);
    @(negedge clk);
    rx_valid = 1; rx_id = id; rx_ext = ext; rx_rtr = rtr;
    @(negedge clk);
    rx_valid = 0; rx_rtr = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
  endtask

  task automatic t_reset();
    check("R1 rx_hit", 32'(rx_hit), 0);
    check("R1 tx_valid", 32'(tx_valid), 0);
    check("R1 ts", 32'(ts), 0);
    check("R1 rdy", 32'(rdy), 0);
  endtask

  task automatic t_rx_basic();
    cfg_slot(2, 29'h123, 0, 0, 0, 1);
    cfg_slot(5, 29'h123, 0, 0, 0, 1);
    send_rx(29'h123, 0, 0);
    check("R3 hit", 32'(rx_hit), 1);
    check("R3 lowest idx", 32'(rx_idx), 2);
    check("R3 slot full", 32'(rdy[2]), 0);
    @(negedge clk);
    check("R11 one cycle", 32'(rx_hit), 0);
    send_rx(29'h123, 0, 0);
    check("R3 next idx", 32'(rx_idx), 5);
    send_rx(29'h124, 0, 0);
    check("R2 mask compares", 32'(rx_hit), 0);
    send_rx(29'h123, 0, 0);
    check("R4 no match", 32'(rx_hit), 0);
    check("R4 rdy unchanged", 32'(rdy), 0);
  endtask

  task automatic t_mask();
    set_mask(0, 29'h1FFFFFF0);
    cfg_slot(6, 29'h120, 0, 0, 0, 1);
    send_rx(29'h12A, 0, 0);
    check("R2 dont-care hit", 32'(rx_hit), 1);
    check("R2 dont-care idx", 32'(rx_idx), 6);
    set_mask(0, 29'h1FFFFFFF);
  endtask

  task automatic t_catch();
    set_mask(1, 29'h0);
    cfg_slot(14, 29'h0, 0, 0, 0, 1);
    cfg_slot(8, 29'h300, 0, 0, 0, 1);
    send_rx(29'h300, 0, 0);
    check("R4 regular first", 32'(rx_idx), 8);
    check("R4 catch kept", 32'(rdy[14]), 1);
    send_rx(29'h777, 0, 0);
    check("R4 catch hit", 32'(rx_hit), 1);
    check("R4 catch idx", 32'(rx_idx), 14);
    send_rx(29'h777, 0, 0);
    check("R4 catch full", 32'(rx_hit), 0);
  endtask

  task automatic t_ext();
    cfg_slot(3, 29'h1ABCDEF1, 1, 0, 0, 1);
    send_rx(29'h6F1, 0, 0);
    check("R5 std vs ext", 32'(rx_hit), 0);
    send_rx(29'h1ABCDEF0, 1, 0);
    check("R5 bit0 differs", 32'(rx_hit), 0);
    send_rx(29'h1ABCDEF1, 1, 0);
    check("R5 ext hit", 32'(rx_hit), 1);
    check("R5 ext idx", 32'(rx_idx), 3);
  endtask

  task automatic t_ts_capture();
    logic [15:0] v;
    @(negedge clk); tick = 1;
    repeat (5) @(negedge clk);
    tick = 0;
    check("R9 counted", 32'(ts), 5);
    v = ts;
    cfg_slot(10, 29'h42, 0, 0, 0, 1);
    send_rx(29'h42, 0, 0);
    check("R10 rx idx", 32'(rx_idx), 10);
    ts_rd_idx = 10;
    #1;
    check("R10 rx stamp", 32'(ts_rd), 32'(v));
  endtask

  task automatic t_tx_arb();
    logic [15:0] v;
    cfg_slot(7, 29'h10, 0, 1, 9, 1);
    cfg_slot(9, 29'h11, 0, 1, 9, 1);
    cfg_slot(1, 29'h12, 0, 1, 3, 1);
    check("R7 first offer", 32'({tx_valid, tx_idx}), 32'({1'b1, 4'd7}));
    cfg_slot(12, 29'h13, 0, 1, 15, 1);
    @(negedge clk);
    check("R8 held", 32'({tx_valid, tx_idx}), 32'({1'b1, 4'd7}));
    pulse_done();
    check("R8 done drops", 32'(tx_valid), 0);
    check("R8 done clears", 32'(rdy[7]), 0);
    @(negedge clk);
    check("R7 highest prio", 32'({tx_valid, tx_idx}), 32'({1'b1, 4'd12}));
    cfg_slot(7, 29'h10, 0, 1, 9, 1);
    v = ts;
    pulse_done();
    ts_rd_idx = 12;
    #1;
    check("R10 tx stamp", 32'(ts_rd), 32'(v));
    @(negedge clk);
    check("R7 tie low idx", 32'(tx_idx), 7);
    @(negedge clk); tx_lost = 1;
    @(negedge clk); tx_lost = 0;
    check("R8 lost drops", 32'(tx_valid), 0);
    check("R8 lost keeps rdy", 32'(rdy[7]), 1);
    @(negedge clk);
    check("R8 rearbitrate", 32'({tx_valid, tx_idx}), 32'({1'b1, 4'd7}));
    pulse_done(); @(negedge clk);
    check("R7 next", 32'(tx_idx), 9);
    pulse_done(); @(negedge clk);
    check("R7 lowest prio", 32'(tx_idx), 1);
    pulse_done(); @(negedge clk);
    check("R7 none left", 32'(tx_valid), 0);
  endtask

  task automatic t_remote();
    cfg_slot(4, 29'h55, 0, 1, 2, 0);
    send_rx(29'h55, 0, 1);
    check("R6 hit", 32'({rx_hit, rx_rmt, rx_idx}), 32'({1'b1, 1'b1, 4'd4}));
    check("R6 armed", 32'(rdy[4]), 1);
    @(negedge clk);
    check("R6 offered", 32'({tx_valid, tx_idx}), 32'({1'b1, 4'd4}));
    pulse_done();
    send_rx(29'h56, 0, 1);
    check("R6 no match", 32'(rx_hit), 0);
  endtask

  task automatic t_wrap();
    int n;
    @(negedge clk);
    n = 16'hFFFF - int'(ts);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
    check("R9 top", 32'(ts), 32'hFFFF);
    @(negedge clk);
    check("R9 holds", 32'(ts), 32'hFFFF);
    tick = 1;
    @(negedge clk);
    tick = 0;
    check("R9 wrap", 32'(ts), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_rx_basic();
    t_mask();
    t_catch();
    t_ext();
    t_ts_capture();
    t_tx_arb();
    t_remote();
    t_wrap();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule